// File: doc/BRIEF.md
# Writeback Scoreboard Queue

This block is an in-order queue of pending writeback records for a pipelined 32-bit core. Execute pushes one record per retiring instruction and writeback pops them in the same order. Each record is one of four kinds: an ALU result with a destination register and a data word, a load with only a destination register, a store marker, or a host marker.

Two search ports run in parallel over the queued records, each comparing a register index against every occupied slot. Issue logic can then test both source operands of one instruction in the same cycle. Only ALU and load records can produce a hit, because only those kinds will write a register. What to do with a hit, such as holding the instruction, is left to the surrounding logic.

Top module: `wbq_top`

## Requirements
- R1: Records leave in the order they were accepted. While the queue is not empty, `first_kind`, `first_dst` and `first_data` show the oldest record exactly as it was pushed. Kind codes are 0 for an ALU result, 1 for a load, 2 for a store and 3 for a host marker.
- R2: A search port asserts its hit output when an occupied slot holds an ALU-result record (kind 0) whose destination equals that port's key.
- R3: A search port asserts its hit output when an occupied slot holds a load record (kind 1) whose destination equals that port's key.
- R4: Store records (kind 2) and host records (kind 3) never cause a hit, whatever values their destination and data fields carry.
- R5: The two search ports are evaluated in the same cycle with separate keys, and each hit output depends only on its own key.
- R6: Hit outputs are combinational from the current contents and the key. A slot whose record has already been popped does not produce a hit.
- R7: A push and a pop in the same cycle are both accepted when the queue is full. A record being popped in a cycle still counts toward that cycle's hit outputs.
- R8: The depth is set by the parameter `DEPTH` (default 4), and `full` rises once `DEPTH` records are held. A push while full without a pop in the same cycle is dropped, and so is a pop while empty. Either one sets `err`, which stays set until reset.
- R9: A synchronous active-high reset empties the queue, clears `err` and drives both hit outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Push request |
| enq_kind | input | 2 | Kind of the pushed record |
| enq_dst | input | 5 | Destination register of the pushed record |
| enq_data | input | 32 | Data word or host payload of the pushed record |
| deq_req | input | 1 | Pop request |
| full | output | 1 | Queue holds DEPTH records |
| empty | output | 1 | Queue holds no record |
| first_kind | output | 2 | Kind of the oldest record |
| first_dst | output | 5 | Destination field of the oldest record |
| first_data | output | 32 | Data field of the oldest record |
| key_a | input | 5 | Register index searched by port A |
| hit_a | output | 1 | Port A found a pending register write |
| key_b | input | 5 | Register index searched by port B |
| hit_b | output | 1 | Port B found a pending register write |
| err | output | 1 | Sticky flag for a dropped push or pop |

## Verification
The bench builds the block with the default depth of 4. A random mix of pushes and pops therefore fills and drains the queue often, and the pointers wrap past slot 3 many times. This exercises the full-queue push-and-pop case, the sticky error flag, and searches in which a popped slot has been reused. Keys and destinations are drawn from the range 0 to 7, so both ports hit often, and store and host records are often queued with a destination that matches a key.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

    localparam int REG_W  = 5;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WBK_ALU   = 2'd0,
        WBK_LOAD  = 2'd1,
        WBK_STORE = 2'd2,
        WBK_HOST  = 2'd3
    } wbq_kind_e;

    typedef struct packed {
        wbq_kind_e          kind;
        logic [REG_W-1:0]   dst;
        logic [WORD_W-1:0]  data;
    } wbq_rec_t;

    // True when the record will eventually write a register.
    function automatic logic writes_reg(input wbq_rec_t rec);
        return (rec.kind == WBK_ALU) || (rec.kind == WBK_LOAD);
    endfunction

    // Search match of one record against one register index.
    function automatic logic rec_hits(input wbq_rec_t rec, input logic [REG_W-1:0] key);
        return writes_reg(rec) && (rec.dst == key);
    endfunction

endpackage

// File: rtl/wbq_store.sv
module wbq_store
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic                 pop,
    input  wbq_rec_t             push_rec,
    output wbq_rec_t [DEPTH-1:0] slots,
    output logic     [DEPTH-1:0] occ,
    output wbq_rec_t             head_rec,
    output logic                 full,
    output logic                 empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] head, tail;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        else                     return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
            occ  <= '0;
        end else begin
            if (pop) begin
                occ[head] <= 1'b0;
                head      <= step_ptr(head);
            end
            if (push) begin
                occ[tail] <= 1'b1;
                tail      <= step_ptr(tail);
            end
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[tail] <= push_rec;
    end

    assign head_rec = slots[head];
    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);

endmodule

// File: rtl/wbq_match.sv
module wbq_match
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  wbq_rec_t [DEPTH-1:0] slots,
    input  logic     [DEPTH-1:0] occ,
    input  logic     [REG_W-1:0] key,
    output logic                 hit
);

    logic [DEPTH-1:0] slot_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_hit[g] = occ[g] && rec_hits(slots[g], key);
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/wbq_top.sv
module wbq_top
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enq_valid,
    input  logic [1:0]  enq_kind,
    input  logic [4:0]  enq_dst,
    input  logic [31:0] enq_data,
    input  logic        deq_req,
    output logic        full,
    output logic        empty,
    output logic [1:0]  first_kind,
    output logic [4:0]  first_dst,
    output logic [31:0] first_data,
    input  logic [4:0]  key_a,
    output logic        hit_a,
    input  logic [4:0]  key_b,
    output logic        hit_b,
    output logic        err
);

    wbq_rec_t             in_rec, head_rec;
    wbq_rec_t [DEPTH-1:0] slots;
    logic     [DEPTH-1:0] occ;
    logic                 push, pop, bad_push, bad_pop;

    assign in_rec.kind = wbq_kind_e'(enq_kind);
    assign in_rec.dst  = enq_dst;
    assign in_rec.data = enq_data;

    // A full queue takes a new record only when one leaves in the same cycle.
    assign pop      = deq_req && !empty;
    assign push     = enq_valid && (!full || pop);
    assign bad_push = enq_valid && !push;
    assign bad_pop  = deq_req && empty;

    wbq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_rec (in_rec),
        .slots    (slots),
        .occ      (occ),
        .head_rec (head_rec),
        .full     (full),
        .empty    (empty)
    );

    wbq_match #(.DEPTH(DEPTH)) u_match_a (
        .slots (slots),
        .occ   (occ),
        .key   (key_a),
        .hit   (hit_a)
    );

    wbq_match #(.DEPTH(DEPTH)) u_match_b (
        .slots (slots),
        .occ   (occ),
        .key   (key_b),
        .hit   (hit_b)
    );

    always_ff @(posedge clk) begin
        if (rst)                       err <= 1'b0;
        else if (bad_push || bad_pop)  err <= 1'b1;
    end

    assign first_kind = head_rec.kind;
    assign first_dst  = head_rec.dst;
    assign first_data = head_rec.data;

endmodule

// File: rtl/wbq_chk.sv
module wbq_chk (
    input logic       clk,
    input logic       rst,
    input logic       enq_valid,
    input logic       deq_req,
    input logic       full,
    input logic       empty,
    input logic [4:0] first_dst,
    input logic       hit_a,
    input logic       hit_b,
    input logic       err
);

    // R8
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R8
    push_on_full_err_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && full && !deq_req) |=> err);

    // R8
    pop_on_empty_err_chk: assert property (@(posedge clk) disable iff (rst)
        (deq_req && empty) |=> err);

    // R6
    empty_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!hit_a && !hit_b));

    // R1
    idle_head_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !enq_valid && !deq_req) |=> (!empty && $stable(first_dst)));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && !err && !hit_a && !hit_b));

endmodule

bind wbq_top wbq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .deq_req   (deq_req),
    .full      (full),
    .empty     (empty),
    .first_dst (first_dst),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .err       (err)
);

// File: tb/wbq_top_tb.sv
module wbq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_DEPTH   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic [1:0]  enq_kind = '0;
    logic [4:0]  enq_dst = '0;
    logic [31:0] enq_data = '0;
    logic        deq_req = 1'b0;
    logic [4:0]  key_a = '0, key_b = '0;
    logic        full, empty, hit_a, hit_b, err;
    logic [1:0]  first_kind;
    logic [4:0]  first_dst;
    logic [31:0] first_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [38:0] mq[$];
    logic        m_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbq_top #(.DEPTH(TB_DEPTH)) u_dut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_kind(enq_kind),
        .enq_dst(enq_dst), .enq_data(enq_data), .deq_req(deq_req),
        .full(full), .empty(empty), .first_kind(first_kind),
        .first_dst(first_dst), .first_data(first_data),
        .key_a(key_a), .hit_a(hit_a), .key_b(key_b), .hit_b(hit_b), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hit from the reference queue: only kinds 0 and 1 count.
    function automatic logic model_hit(input logic [4:0] key);
        foreach (mq[i])
            if (mq[i][38:37] < 2'd2 && mq[i][36:32] == key) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_now(input string tag);
        chk({tag, " R2 R3 R4 R5 R6 hit_a"}, {31'd0, hit_a}, {31'd0, model_hit(key_a)});
        chk({tag, " R2 R3 R4 R5 R6 hit_b"}, {31'd0, hit_b}, {31'd0, model_hit(key_b)});
        chk({tag, " R8 full"},  {31'd0, full},  {31'd0, mq.size() == TB_DEPTH});
        chk({tag, " R8 empty"}, {31'd0, empty}, {31'd0, mq.size() == 0});
        chk({tag, " R8 err"},   {31'd0, err},   {31'd0, m_err});
        if (mq.size() > 0) begin
            chk({tag, " R1 first_kind"}, {30'd0, first_kind}, {30'd0, mq[0][38:37]});
            chk({tag, " R1 first_dst"},  {27'd0, first_dst},  {27'd0, mq[0][36:32]});
            chk({tag, " R1 first_data"}, first_data, mq[0][31:0]);
        end
    endtask

    task automatic step(input string tag, input logic ev, input logic [1:0] k,
                        input logic [4:0] d, input logic [31:0] dt, input logic dq,
                        input logic [4:0] ka, input logic [4:0] kb);
        logic do_pop, do_push;
        @(negedge clk);
        enq_valid = ev; enq_kind = k; enq_dst = d; enq_data = dt;
        deq_req = dq; key_a = ka; key_b = kb;
        #1;
        check_now(tag);
        do_pop  = dq && mq.size() > 0;
        do_push = ev && (mq.size() < TB_DEPTH || do_pop);
        if ((ev && !do_push) || (dq && mq.size() == 0)) m_err = 1'b1;
        @(posedge clk);
        if (do_pop)  void'(mq.pop_front());
        if (do_push) mq.push_back({k, d, dt});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; enq_valid = 1'b0; deq_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
        m_err = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        do_reset();
        // R9: state right after reset
        #1;
        chk("R9 empty after reset", {31'd0, empty}, 32'd1);
        chk("R9 err after reset",   {31'd0, err},   32'd0);
        chk("R9 hit_a after reset", {31'd0, hit_a}, 32'd0);
        chk("R9 hit_b after reset", {31'd0, hit_b}, 32'd0);

        // R2 ALU record hits on its destination only
        step("R2 push alu", 1, 2'd0, 5'd5, 32'hAAAA0005, 0, 5'd5, 5'd6);
        step("R2 search",   0, 2'd0, 5'd0, 32'h0, 0, 5'd5, 5'd6);
        // R4 store and host records with a matching destination
        step("R4 push store", 1, 2'd2, 5'd9, 32'h0, 0, 5'd9, 5'd9);
        step("R4 push host",  1, 2'd3, 5'd9, 32'hDEAD0009, 0, 5'd9, 5'd9);
        step("R4 search",     0, 2'd0, 5'd0, 32'h0, 0, 5'd9, 5'd9);
        // R3 load record, queue now full
        step("R3 push load",  1, 2'd1, 5'd3, 32'h0, 0, 5'd3, 5'd9);
        // R5 independent ports: A on the load, B on the ALU record
        step("R5 two keys",   0, 2'd0, 5'd0, 32'h0, 0, 5'd3, 5'd5);
        // R8 push on full is dropped and raises err
        step("R8 push full",  1, 2'd0, 5'd7, 32'h7, 0, 5'd7, 5'd3);
        step("R8 after drop", 0, 2'd0, 5'd0, 32'h0, 0, 5'd7, 5'd3);
        // R7 push and pop on full; popping head still hits
        step("R7 full swap",  1, 2'd0, 5'd12, 32'hC, 1, 5'd5, 5'd12);
        // R6 popped record no longer hits; slot reused by reg 12
        step("R6 popped gone", 0, 2'd0, 5'd0, 32'h0, 0, 5'd5, 5'd12);
        for (int i = 0; i < 4; i++)
            step("R1 drain", 0, 2'd0, 5'd0, 32'h0, 1, 5'd3, 5'd12);
        // R8 pop on empty
        step("R8 pop empty", 0, 2'd0, 5'd0, 32'h0, 1, 5'd0, 5'd0);
        step("R8 err held",  0, 2'd0, 5'd0, 32'h0, 0, 5'd0, 5'd0);
        do_reset();
        #1;
        chk("R9 err cleared", {31'd0, err}, 32'd0);
        chk("R9 empty again", {31'd0, empty}, 32'd1);

        // Random mix of all four kinds
        for (int i = 0; i < 4000; i++) begin
            step("R1 random",
                 ($urandom % 10) < 6, 2'($urandom % 4), 5'($urandom % 8), $urandom,
                 ($urandom % 2) == 1, 5'($urandom % 8), 5'($urandom % 8));
        end
        for (int i = 0; i < 6; i++)
            step("R1 final drain", 0, 2'd0, 5'd0, 32'h0, 1, 5'd1, 5'd2);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule